// File: doc/BRIEF.md
# Operand Shifter with Carry Generation

This block shifts or rotates a 32-bit operand on its way into an ALU. One code picks the operation: a logical shift left or right, an arithmetic shift right, a rotate right, or a one-bit rotate right through the carry flag. A 5-bit amount sets the distance for the first four operations. The block also produces a carry-out that the ALU can use for its flags. For a nonzero shift, the carry-out is the last bit that leaves the operand. For a zero shift, the incoming carry passes through unchanged.

The block is purely combinational and holds no state. Both outputs follow the inputs in the same cycle, so a datapath can place it directly in front of its adder or logic unit. The width is a parameter with a default of 32, and the amount width is derived from it.

Top module: `barrel_shift_unit`

## Requirements
- R1: With kind code 0 (shift left), the result is the operand moved left by the amount, and the vacated low bits are filled with 0.
- R2: With kind code 1 (logical shift right), the result is the operand moved right by the amount, and the vacated high bits are filled with 0.
- R3: With kind code 2 (arithmetic shift right), the result is the operand moved right by the amount, and every vacated high bit is a copy of the original bit 31.
- R4: With kind code 3 (rotate right), the bits that leave bit 0 re-enter at bit 31, so no bit is lost.
- R5: With kind code 4 (extended rotate), the amount is ignored. The result is the carry input followed by operand bits 31 down to 1, and the carry-out is operand bit 0.
- R6: For codes 0 to 3 with a nonzero amount n, the carry-out is the last bit shifted out. For code 0 this is operand bit 32-n. For codes 1, 2 and 3 it is operand bit n-1.
- R7: For codes 0 to 3 with an amount of 0, the result equals the operand and the carry-out equals the carry input.
- R8: Codes 5, 6 and 7 are reserved. With any of them, the result equals the operand and the carry-out equals the carry input, whatever the amount.
- R9: The block has no clock and no storage. Both outputs are valid in the same cycle as the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted or rotated |
| kind_i | input | 3 | Operation code (0 shift left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 extended rotate, 5 to 7 reserved) |
| amount_i | input | 5 | Shift distance for codes 0 to 3 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | Carry-out produced by the shifter |

## Verification
Every result of this block is due zero cycles after its stimulus, because nothing is registered between the inputs and the outputs. The bench therefore applies each input set on a falling clock edge and compares both outputs a few nanoseconds later, inside the same cycle and well before the next rising edge. A fixed vector table covers the known corner cases. A sweep then crosses every kind code with every amount over edge and random operands, and each output is compared with a bit-by-bit behavioural model.

// File: rtl/shf_pkg.sv
// Package: shared definitions for the operand shifter.
// Assumes a 3-bit operation code; codes above SK_RRX are reserved.
package shf_pkg;
    localparam int SHF_KIND_W = 3;

    typedef enum logic [SHF_KIND_W-1:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4
    } shf_kind_e;
endpackage

// File: rtl/shf_bitrev.sv
// Module: shf_bitrev
// Mirrors a vector end for end, so that bit i moves to bit WIDTH-1-i.
// Used so that a left shift can run through the right-shift network.
// Assumes WIDTH >= 1; the module is pure wiring.
module shf_bitrev #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] vec_o
);
    // One wire per bit position, crossed over.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign vec_o[i] = vec_i[WIDTH-1-i];
    end
endmodule

// File: rtl/shf_rstage.sv
// Module: shf_rstage
// One stage of a logarithmic right shifter, with a fixed distance of SHIFT.
// When enabled, it either shifts in copies of fill_i or wraps the low bits
// around to the top. Assumes 0 < SHIFT < WIDTH.
module shf_rstage #(
    parameter int WIDTH = 32,
    parameter int SHIFT = 1
) (
    input  logic [WIDTH-1:0] vec_i,
    input  logic             en_i,
    input  logic             rot_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] vec_o
);
    logic [WIDTH-1:0] filled;
    logic [WIDTH-1:0] wrapped;

    assign filled  = {{SHIFT{fill_i}}, vec_i[WIDTH-1:SHIFT]};
    assign wrapped = {vec_i[SHIFT-1:0], vec_i[WIDTH-1:SHIFT]};

    // Select bypass, fill shift or wrap for this stage.
    always_comb begin
        if (!en_i)      vec_o = vec_i;
        else if (rot_i) vec_o = wrapped;
        else            vec_o = filled;
    end
endmodule

// File: rtl/shf_carry_pick.sv
// Module: shf_carry_pick
// Returns the bit of the pre-shift vector that leaves last in a right
// shift by amount_i, which is bit amount_i-1. Assumes the caller handles
// amount_i == 0 and presents a left shift in mirrored form.
module shf_carry_pick #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 5
) (
    input  logic [WIDTH-1:0] vec_i,
    input  logic [AMT_W-1:0] amount_i,
    output logic             bit_o
);
    logic [AMT_W-1:0] idx;

    assign idx   = amount_i - AMT_W'(1);
    assign bit_o = vec_i[idx];
endmodule

// File: rtl/barrel_shift_unit.sv
// Module: barrel_shift_unit
// A combinational shifter that feeds an ALU operand. It supports shift
// left, logical and arithmetic shift right, rotate right, and a one-bit
// rotate right through carry. It also produces a carry-out for each mode.
// Assumes WIDTH is a power of two; the amount width is derived from it.
// A left shift runs through a mirrored copy of the right-shift network.
module barrel_shift_unit
    import shf_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]      operand_i,
    input  logic [SHF_KIND_W-1:0] kind_i,
    input  logic [AMT_W-1:0]      amount_i,
    input  logic                  carry_i,
    output logic [WIDTH-1:0]      result_o,
    output logic                  carry_o
);
    logic is_lsl, is_lsr, is_asr, is_ror, is_rrx, is_shift;
    logic [WIDTH-1:0] mirrored_in;
    logic [WIDTH-1:0] pre_vec;
    logic [WIDTH-1:0] net_out;
    logic [WIDTH-1:0] mirrored_out;
    logic [WIDTH-1:0] shifted;
    logic             fill_bit;
    logic             last_out;
    logic [WIDTH-1:0] stage_vec [AMT_W+1];

    assign is_lsl   = (kind_i == SK_LSL);
    assign is_lsr   = (kind_i == SK_LSR);
    assign is_asr   = (kind_i == SK_ASR);
    assign is_ror   = (kind_i == SK_ROR);
    assign is_rrx   = (kind_i == SK_RRX);
    assign is_shift = is_lsl | is_lsr | is_asr | is_ror;

    shf_bitrev #(.WIDTH(WIDTH)) u_rev_in (
        .vec_i (operand_i),
        .vec_o (mirrored_in)
    );

    assign pre_vec      = is_lsl ? mirrored_in : operand_i;
    assign fill_bit     = is_asr & operand_i[WIDTH-1];
    assign stage_vec[0] = pre_vec;

    // One stage per bit of the amount, with distances 1, 2, 4 and so on.
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        shf_rstage #(.WIDTH(WIDTH), .SHIFT(1 << k)) u_stage (
            .vec_i  (stage_vec[k]),
            .en_i   (amount_i[k]),
            .rot_i  (is_ror),
            .fill_i (fill_bit),
            .vec_o  (stage_vec[k+1])
        );
    end

    assign net_out = stage_vec[AMT_W];

    shf_bitrev #(.WIDTH(WIDTH)) u_rev_out (
        .vec_i (net_out),
        .vec_o (mirrored_out)
    );

    assign shifted = is_lsl ? mirrored_out : net_out;

    shf_carry_pick #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_carry (
        .vec_i    (pre_vec),
        .amount_i (amount_i),
        .bit_o    (last_out)
    );

    // Final selection of result and carry by operation and amount.
    always_comb begin
        if (is_rrx) begin
            result_o = {carry_i, operand_i[WIDTH-1:1]};
            carry_o  = operand_i[0];
        end else if (is_shift && (amount_i != '0)) begin
            result_o = shifted;
            carry_o  = last_out;
        end else begin
            result_o = operand_i;
            carry_o  = carry_i;
        end
    end

    // Property checks on the finished outputs, skipped while inputs are unknown.
    always_comb begin
        if (!$isunknown({operand_i, kind_i, amount_i, carry_i})) begin
            if (is_lsl && amount_i != '0)
                a_r1_low_zero : assert (result_o[0] == 1'b0);
            if (is_lsr && amount_i != '0)
                a_r2_top_zero : assert (result_o[WIDTH-1] == 1'b0);
            if (is_asr)
                a_r3_sign_kept : assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
            if (is_ror)
                a_r4_ones_kept : assert ($countones(result_o) == $countones(operand_i));
            if (is_rrx)
                a_r5_carry_rot : assert (result_o[WIDTH-1] == carry_i && carry_o == operand_i[0]);
            if (is_shift && amount_i == '0)
                a_r7_zero_pass : assert (result_o == operand_i && carry_o == carry_i);
            if (!is_shift && !is_rrx)
                a_r8_reserved_pass : assert (result_o == operand_i && carry_o == carry_i);
        end
    end
endmodule

// File: tb/barrel_shift_unit_tb.sv
// Bench: a vector table walked by one loop, then an exhaustive sweep over
// kinds and amounts against a behavioural model, then directed checks.
module barrel_shift_unit_tb_top;
    localparam int W = 32;
    localparam int CYCLE_NS = 20;
    localparam int LIMIT_CYCLES = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  operand;
    logic [2:0]    kind;
    logic [4:0]    amount;
    logic          carry_in;
    logic [W-1:0]  result;
    logic          carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CYCLE_NS/2) clk = ~clk;

    barrel_shift_unit dut_i (
        .operand_i (operand),
        .kind_i    (kind),
        .amount_i  (amount),
        .carry_i   (carry_in),
        .result_o  (result),
        .carry_o   (carry_out)
    );

    typedef struct packed {
        logic [3:0]   req;
        logic [2:0]   k;
        logic [4:0]   n;
        logic         c;
        logic [31:0]  d;
        logic [31:0]  r;
        logic         co;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd3, 3'd2, 5'd4,  1'b0, 32'h12345678, 32'h01234567, 1'b1}, // R3
        '{4'd3, 3'd2, 5'd4,  1'b0, 32'h80000000, 32'hF8000000, 1'b0}, // R3
        '{4'd1, 3'd0, 5'd1,  1'b0, 32'h80000001, 32'h00000002, 1'b1}, // R1
        '{4'd2, 3'd1, 5'd31, 1'b1, 32'h80000000, 32'h00000001, 1'b0}, // R2
        '{4'd4, 3'd3, 5'd8,  1'b1, 32'h12345678, 32'h78123456, 1'b0}, // R4
        '{4'd5, 3'd4, 5'd7,  1'b1, 32'h00000003, 32'h80000001, 1'b1}, // R5
        '{4'd7, 3'd0, 5'd0,  1'b1, 32'hDEADBEEF, 32'hDEADBEEF, 1'b1}, // R7
        '{4'd8, 3'd6, 5'd5,  1'b0, 32'hCAFEF00D, 32'hCAFEF00D, 1'b0}, // R8
        '{4'd6, 3'd1, 5'd1,  1'b0, 32'h00000001, 32'h00000000, 1'b1}, // R6
        '{4'd3, 3'd2, 5'd31, 1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b0}, // R3
        '{4'd4, 3'd3, 5'd1,  1'b0, 32'h00000001, 32'h80000000, 1'b1}, // R4
        '{4'd6, 3'd0, 5'd31, 1'b1, 32'h00000001, 32'h80000000, 1'b0}  // R6
    };

    // Behavioural model built from the requirements, returning {carry, result}.
    function automatic logic [W:0] model(input logic [W-1:0] d, input logic [2:0] k,
                                         input int n, input logic c);
        logic [W-1:0] r;
        logic         co;
        r  = d;
        co = c;
        case (k)
            3'd0: if (n != 0) begin
                for (int i = 0; i < W; i++) r[i] = (i >= n) ? d[i-n] : 1'b0;
                co = d[W-n];
            end
            3'd1: if (n != 0) begin
                for (int i = 0; i < W; i++) r[i] = (i + n < W) ? d[i+n] : 1'b0;
                co = d[n-1];
            end
            3'd2: if (n != 0) begin
                for (int i = 0; i < W; i++) r[i] = (i + n < W) ? d[i+n] : d[W-1];
                co = d[n-1];
            end
            3'd3: if (n != 0) begin
                for (int i = 0; i < W; i++) r[i] = d[(i + n) % W];
                co = d[n-1];
            end
            3'd4: begin
                r  = {c, d[W-1:1]};
                co = d[0];
            end
            default: ;
        endcase
        return {co, r};
    endfunction

    task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got carry=%0b result=%08h, expected carry=%0b result=%08h",
                     tag, got[W], got[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic apply(input logic [W-1:0] d, input logic [2:0] k,
                         input logic [4:0] n, input logic c);
        @(negedge clk);
        operand  = d;
        kind     = k;
        amount   = n;
        carry_in = c;
        #2;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (LIMIT_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no end, expected end within %0d cycles", LIMIT_CYCLES);
            finish_run();
        end
    end

    initial begin : stim
        logic [W-1:0] ops [8];
        operand = '0; kind = '0; amount = '0; carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs give zero result and zero carry (R7, R9).
        apply('0, 3'd0, 5'd0, 1'b0);
        check("R9 idle", {carry_out, result}, {1'b0, 32'h0});

        // Table walk.
        for (int v = 0; v < NVEC; v++) begin
            apply(VECS[v].d, VECS[v].k, VECS[v].n, VECS[v].c);
            check($sformatf("R%0d table[%0d]", VECS[v].req, v),
                  {carry_out, result}, {VECS[v].co, VECS[v].r});
        end

        // Masked arithmetic shift result from the table operand (R3).
        apply(32'h12345678, 3'd2, 5'd4, 1'b0);
        check("R3 masked", {1'b0, result & 32'h000003FF}, {1'b0, 32'h00000167});

        // Sweep every kind and amount over edge and random operands (R1..R8 by model).
        ops[0] = 32'h00000000; ops[1] = 32'hFFFFFFFF;
        ops[2] = 32'h80000000; ops[3] = 32'h00000001;
        for (int j = 4; j < 8; j++) ops[j] = $urandom();
        for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 8; k++) begin
                for (int n = 0; n < W; n++) begin
                    logic c;
                    c = logic'((j + n + k) & 1);
                    apply(ops[j], 3'(k), 5'(n), c);
                    check($sformatf("R6 sweep kind=%0d amt=%0d", k, n),
                          {carry_out, result}, model(ops[j], 3'(k), n, c));
                end
            end
        end

        // R5: the amount has no effect on the extended rotate.
        apply(32'h0000_0002, 3'd4, 5'd0, 1'b0);
        check("R5 amt0", {carry_out, result}, {1'b0, 32'h00000001});
        apply(32'h0000_0002, 3'd4, 5'd31, 1'b0);
        check("R5 amt31", {carry_out, result}, {1'b0, 32'h00000001});

        // R8: reserved code with a large amount leaves the operand untouched.
        apply(32'h5A5A_0F0F, 3'd7, 5'd17, 1'b1);
        check("R8 code7", {carry_out, result}, {1'b1, 32'h5A5A0F0F});

        // R2: a logical right shift of an all-ones value by 16 fills zeros.
        apply(32'hFFFF_FFFF, 3'd1, 5'd16, 1'b0);
        check("R2 fill", {carry_out, result}, {1'b1, 32'h0000FFFF});

        done = 1'b1;
        finish_run();
    end
endmodule